// File: doc/BRIEF.md
# Double-Indexed DMA Byte Address Generator

This block walks through the byte addresses of one DMA block transfer. The transfer is split into elements, and elements are grouped into frames. A start pulse loads the configuration: a start address, a block size in bytes, an element size in bytes, the number of elements in a frame, and two signed 16-bit offsets. One offset is applied at each element boundary and the other at each frame boundary. After the start pulse, the block shows the address of byte 0. Each `next_i` strobe then moves it on by one byte.

Inside an element the address goes up by one. When a new element begins, the element offset is added to the previous address. When a new frame begins, the frame offset is added instead. The frame rule wins when both boundaries fall on the same byte. Two flags report which jump produced the current address, and `done_o` marks the last byte. A data mover reads the address, performs its access, and then pulses `next_i`.

Top module: `dma_idx_agen`

## Requirements
- R1: After reset, `valid_o`, `done_o`, `elem_bnd_o` and `frame_bnd_o` are all 0.
- R2: A `start_i` pulse while `valid_o` is 0 makes `valid_o` 1 in the next cycle. In that cycle `addr_o` equals the start address and both boundary flags are 0.
- R3: On `next_i`, when byte index i+1 is a multiple of neither the element size nor the frame size, the next address is the current address plus 1 and both flags are 0.
- R4: On `next_i`, when i+1 is a multiple of the element size but not of the frame size, the sign-extended element offset is added and `elem_bnd_o` is 1.
- R5: On `next_i`, when i+1 is a multiple of the frame size (element size times elements per frame), the sign-extended frame offset is added and `frame_bnd_o` is 1. This rule takes precedence over R4.
- R6: `done_o` is 1 exactly while the byte with index block size − 1 is shown. A `next_i` in that state makes `valid_o` 0.
- R7: While `next_i` is 0 during a transfer, `addr_o` and `valid_o` hold their values.
- R8: A `start_i` pulse while `valid_o` is 1 has no effect on the address sequence.
- R9: An element size, element count or block size of zero is treated as 1.
- R10: Address arithmetic wraps modulo 2^ADDR_W.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Begin a transfer (ignored while active) |
| cfg_start_addr_i | input | ADDR_W | Address of byte 0 |
| cfg_block_size_i | input | BS_W | Bytes in the block |
| cfg_elem_size_i | input | ES_W | Bytes per element |
| cfg_elem_cnt_i | input | EN_W | Elements per frame |
| cfg_elem_idx_i | input | IDX_W | Signed element offset |
| cfg_frame_idx_i | input | IDX_W | Signed frame offset |
| next_i | input | 1 | Advance to the next byte |
| addr_o | output | ADDR_W | Current byte address |
| valid_o | output | 1 | Transfer active, `addr_o` meaningful |
| elem_bnd_o | output | 1 | Current address came from an element jump |
| frame_bnd_o | output | 1 | Current address came from a frame jump |
| done_o | output | 1 | Current byte is the last of the block |

## Verification
The bench uses the default parameters: 32-bit addresses, 16-bit offsets, a 16-bit block size and 8-bit element size and count fields. With these settings, short blocks are enough to cover several frames, to mix negative and positive offsets, to reach zero-valued sizes, and to cross the top of the 32-bit address space. Every address in each run is compared against a model built on modulo arithmetic over the byte index.

// File: rtl/dma_agen_pkg.sv
package dma_agen_pkg;
    typedef enum logic [1:0] {
        STEP_BYTE  = 2'd0,
        STEP_ELEM  = 2'd1,
        STEP_FRAME = 2'd2
    } step_e;
endpackage

// File: rtl/agen_cfg_norm.sv
module agen_cfg_norm #(
    parameter int BS_W = 16,
    parameter int ES_W = 8,
    parameter int EN_W = 8,
    localparam int FS_W = ES_W + EN_W
) (
    input  logic [BS_W-1:0] blk_size_i,
    input  logic [ES_W-1:0] elem_size_i,
    input  logic [EN_W-1:0] elem_cnt_i,
    output logic [ES_W-1:0] es_m1_o,
    output logic [FS_W-1:0] fs_m1_o,
    output logic [BS_W-1:0] last_idx_o
);
    logic [ES_W-1:0] es_eff;
    logic [EN_W-1:0] en_eff;
    logic [BS_W-1:0] bs_eff;
    logic [FS_W-1:0] fs_eff;

    always_comb begin
        es_eff     = (elem_size_i == '0) ? ES_W'(1) : elem_size_i;
        en_eff     = (elem_cnt_i == '0) ? EN_W'(1) : elem_cnt_i;
        bs_eff     = (blk_size_i == '0) ? BS_W'(1) : blk_size_i;
        fs_eff     = {{EN_W{1'b0}}, es_eff} * {{ES_W{1'b0}}, en_eff};
        es_m1_o    = es_eff - ES_W'(1);
        fs_m1_o    = fs_eff - FS_W'(1);
        last_idx_o = bs_eff - BS_W'(1);
    end
endmodule

// File: rtl/agen_pos_track.sv
module agen_pos_track
    import dma_agen_pkg::*;
#(
    parameter int ES_W = 8,
    parameter int FS_W = 16
) (
    input  logic [ES_W-1:0] ecnt_i,
    input  logic [FS_W-1:0] fcnt_i,
    input  logic [ES_W-1:0] es_m1_i,
    input  logic [FS_W-1:0] fs_m1_i,
    output logic [ES_W-1:0] ecnt_nx_o,
    output logic [FS_W-1:0] fcnt_nx_o,
    output step_e           step_o
);
    logic elem_wrap;
    logic frame_wrap;

    always_comb begin
        elem_wrap  = (ecnt_i == es_m1_i);
        frame_wrap = (fcnt_i == fs_m1_i);
        ecnt_nx_o  = elem_wrap ? '0 : ecnt_i + ES_W'(1);
        fcnt_nx_o  = frame_wrap ? '0 : fcnt_i + FS_W'(1);
        if (frame_wrap)     step_o = STEP_FRAME;
        else if (elem_wrap) step_o = STEP_ELEM;
        else                step_o = STEP_BYTE;
    end
endmodule

// File: rtl/agen_step_add.sv
module agen_step_add
    import dma_agen_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int IDX_W  = 16
) (
    input  logic [ADDR_W-1:0] addr_i,
    input  step_e             step_i,
    input  logic [IDX_W-1:0]  elem_idx_i,
    input  logic [IDX_W-1:0]  frame_idx_i,
    output logic [ADDR_W-1:0] addr_nx_o
);
    logic [ADDR_W-1:0] ei_x;
    logic [ADDR_W-1:0] fi_x;

    generate
        if (ADDR_W > IDX_W) begin : g_sext
            assign ei_x = {{(ADDR_W-IDX_W){elem_idx_i[IDX_W-1]}}, elem_idx_i};
            assign fi_x = {{(ADDR_W-IDX_W){frame_idx_i[IDX_W-1]}}, frame_idx_i};
        end else begin : g_trunc
            assign ei_x = elem_idx_i[ADDR_W-1:0];
            assign fi_x = frame_idx_i[ADDR_W-1:0];
        end
    endgenerate

    always_comb begin
        case (step_i)
            STEP_FRAME: addr_nx_o = addr_i + fi_x;
            STEP_ELEM:  addr_nx_o = addr_i + ei_x;
            default:    addr_nx_o = addr_i + ADDR_W'(1);
        endcase
    end
endmodule

// File: rtl/dma_idx_agen.sv
module dma_idx_agen
    import dma_agen_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int IDX_W  = 16,
    parameter int BS_W   = 16,
    parameter int ES_W   = 8,
    parameter int EN_W   = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [ADDR_W-1:0] cfg_start_addr_i,
    input  logic [BS_W-1:0]   cfg_block_size_i,
    input  logic [ES_W-1:0]   cfg_elem_size_i,
    input  logic [EN_W-1:0]   cfg_elem_cnt_i,
    input  logic [IDX_W-1:0]  cfg_elem_idx_i,
    input  logic [IDX_W-1:0]  cfg_frame_idx_i,
    input  logic              next_i,
    output logic [ADDR_W-1:0] addr_o,
    output logic              valid_o,
    output logic              elem_bnd_o,
    output logic              frame_bnd_o,
    output logic              done_o
);
    localparam int FS_W = ES_W + EN_W;

    typedef struct packed {
        logic              active;
        logic [ADDR_W-1:0] addr;
        logic [BS_W-1:0]   idx;
        logic [BS_W-1:0]   last_idx;
        logic [ES_W-1:0]   es_m1;
        logic [FS_W-1:0]   fs_m1;
        logic [ES_W-1:0]   ecnt;
        logic [FS_W-1:0]   fcnt;
        logic [IDX_W-1:0]  ei;
        logic [IDX_W-1:0]  fi;
        logic              elem_bnd;
        logic              frame_bnd;
    } agen_st_t;

    agen_st_t st_d, st_q;

    logic [ES_W-1:0]   norm_es_m1;
    logic [FS_W-1:0]   norm_fs_m1;
    logic [BS_W-1:0]   norm_last;
    logic [ES_W-1:0]   ecnt_nx;
    logic [FS_W-1:0]   fcnt_nx;
    step_e             step_kind;
    logic [ADDR_W-1:0] addr_nx;

    agen_cfg_norm #(.BS_W(BS_W), .ES_W(ES_W), .EN_W(EN_W)) norm_i (
        .blk_size_i  (cfg_block_size_i),
        .elem_size_i (cfg_elem_size_i),
        .elem_cnt_i  (cfg_elem_cnt_i),
        .es_m1_o     (norm_es_m1),
        .fs_m1_o     (norm_fs_m1),
        .last_idx_o  (norm_last)
    );

    agen_pos_track #(.ES_W(ES_W), .FS_W(FS_W)) pos_i (
        .ecnt_i    (st_q.ecnt),
        .fcnt_i    (st_q.fcnt),
        .es_m1_i   (st_q.es_m1),
        .fs_m1_i   (st_q.fs_m1),
        .ecnt_nx_o (ecnt_nx),
        .fcnt_nx_o (fcnt_nx),
        .step_o    (step_kind)
    );

    agen_step_add #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) add_i (
        .addr_i      (st_q.addr),
        .step_i      (step_kind),
        .elem_idx_i  (st_q.ei),
        .frame_idx_i (st_q.fi),
        .addr_nx_o   (addr_nx)
    );

    always_comb begin
        st_d = st_q;
        if (!st_q.active) begin
            if (start_i) begin
                st_d.active    = 1'b1;
                st_d.addr      = cfg_start_addr_i;
                st_d.idx       = '0;
                st_d.last_idx  = norm_last;
                st_d.es_m1     = norm_es_m1;
                st_d.fs_m1     = norm_fs_m1;
                st_d.ecnt      = '0;
                st_d.fcnt      = '0;
                st_d.ei        = cfg_elem_idx_i;
                st_d.fi        = cfg_frame_idx_i;
                st_d.elem_bnd  = 1'b0;
                st_d.frame_bnd = 1'b0;
            end
        end else if (next_i) begin
            if (st_q.idx == st_q.last_idx) begin
                st_d.active    = 1'b0;
                st_d.elem_bnd  = 1'b0;
                st_d.frame_bnd = 1'b0;
            end else begin
                st_d.idx       = st_q.idx + BS_W'(1);
                st_d.ecnt      = ecnt_nx;
                st_d.fcnt      = fcnt_nx;
                st_d.addr      = addr_nx;
                st_d.elem_bnd  = (step_kind == STEP_ELEM);
                st_d.frame_bnd = (step_kind == STEP_FRAME);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign addr_o      = st_q.addr;
    assign valid_o     = st_q.active;
    assign elem_bnd_o  = st_q.elem_bnd;
    assign frame_bnd_o = st_q.frame_bnd;
    assign done_o      = st_q.active && (st_q.idx == st_q.last_idx);
endmodule

// File: rtl/dma_idx_agen_chk.sv
module dma_idx_agen_chk #(
    parameter int ADDR_W = 32,
    parameter int IDX_W  = 16,
    parameter int BS_W   = 16,
    parameter int ES_W   = 8,
    parameter int EN_W   = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start_i,
    input logic [ADDR_W-1:0] cfg_start_addr_i,
    input logic [BS_W-1:0]   cfg_block_size_i,
    input logic [ES_W-1:0]   cfg_elem_size_i,
    input logic [EN_W-1:0]   cfg_elem_cnt_i,
    input logic [IDX_W-1:0]  cfg_elem_idx_i,
    input logic [IDX_W-1:0]  cfg_frame_idx_i,
    input logic              next_i,
    input logic [ADDR_W-1:0] addr_o,
    input logic              valid_o,
    input logic              elem_bnd_o,
    input logic              frame_bnd_o,
    input logic              done_o
);
    // R6
    done_needs_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> valid_o);

    // R5
    flags_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({elem_bnd_o, frame_bnd_o}));

    // R2
    start_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!valid_o && start_i) |=> (valid_o && !elem_bnd_o && !frame_bnd_o
                                   && addr_o == $past(cfg_start_addr_i)));

    // R3
    byte_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_o && next_i && !done_o) |=>
            (valid_o && (elem_bnd_o || frame_bnd_o || addr_o == $past(addr_o) + ADDR_W'(1))));

    // R6
    end_on_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_o && next_i && done_o) |=> !valid_o);

    // R7
    hold_no_next_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_o && !next_i) |=> (valid_o && $stable(addr_o) && $stable(done_o)));
endmodule

bind dma_idx_agen dma_idx_agen_chk #(
    .ADDR_W(ADDR_W), .IDX_W(IDX_W), .BS_W(BS_W), .ES_W(ES_W), .EN_W(EN_W)
) chk_i (
    .clk              (clk),
    .rst_n            (rst_n),
    .start_i          (start_i),
    .cfg_start_addr_i (cfg_start_addr_i),
    .cfg_block_size_i (cfg_block_size_i),
    .cfg_elem_size_i  (cfg_elem_size_i),
    .cfg_elem_cnt_i   (cfg_elem_cnt_i),
    .cfg_elem_idx_i   (cfg_elem_idx_i),
    .cfg_frame_idx_i  (cfg_frame_idx_i),
    .next_i           (next_i),
    .addr_o           (addr_o),
    .valid_o          (valid_o),
    .elem_bnd_o       (elem_bnd_o),
    .frame_bnd_o      (frame_bnd_o),
    .done_o           (done_o)
);

// File: tb/dma_idx_agen_tb.sv
module dma_idx_agen_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [31:0] cfg_start_addr_i = '0;
    logic [15:0] cfg_block_size_i = '0;
    logic [7:0]  cfg_elem_size_i = '0;
    logic [7:0]  cfg_elem_cnt_i = '0;
    logic [15:0] cfg_elem_idx_i = '0;
    logic [15:0] cfg_frame_idx_i = '0;
    logic        next_i = 1'b0;
    logic [31:0] addr_o;
    logic        valid_o;
    logic        elem_bnd_o;
    logic        frame_bnd_o;
    logic        done_o;

    int n_checks = 0;
    int n_fail   = 0;
    int cycles   = 0;

    always #5 clk = ~clk;

    dma_idx_agen dut_i (
        .clk(clk), .rst_n(rst_n), .start_i(start_i),
        .cfg_start_addr_i(cfg_start_addr_i), .cfg_block_size_i(cfg_block_size_i),
        .cfg_elem_size_i(cfg_elem_size_i), .cfg_elem_cnt_i(cfg_elem_cnt_i),
        .cfg_elem_idx_i(cfg_elem_idx_i), .cfg_frame_idx_i(cfg_frame_idx_i),
        .next_i(next_i), .addr_o(addr_o), .valid_o(valid_o),
        .elem_bnd_o(elem_bnd_o), .frame_bnd_o(frame_bnd_o), .done_o(done_o)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual 0x%08h expected 0x%08h", req, what, act, exp);
        end
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            n_fail++;
            n_checks++;
            $display("FAIL watchdog: actual %0d expected <100000 cycles", cycles);
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    // Runs one transfer and compares each byte with a modulo-based model.
    task automatic run_xfer(input logic [31:0] sa, input int bs, input int es, input int en,
                            input logic [15:0] ei, input logic [15:0] fi,
                            input int hold_at, input int restart_at);
        int es_e;
        int fs_e;
        int bs_e;
        logic [31:0] exp_a;
        logic [31:0] ei_x;
        logic [31:0] fi_x;
        bit  exp_e;
        bit  exp_f;
        es_e = (es == 0) ? 1 : es;
        fs_e = es_e * ((en == 0) ? 1 : en);
        bs_e = (bs == 0) ? 1 : bs;
        ei_x = {{16{ei[15]}}, ei};
        fi_x = {{16{fi[15]}}, fi};
        @(negedge clk);
        cfg_start_addr_i = sa;
        cfg_block_size_i = 16'(bs);
        cfg_elem_size_i  = 8'(es);
        cfg_elem_cnt_i   = 8'(en);
        cfg_elem_idx_i   = ei;
        cfg_frame_idx_i  = fi;
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        exp_a = sa;
        check(valid_o == 1'b1, "R2", "valid after start", 32'(valid_o), 32'd1);
        for (int i = 0; i < bs_e; i++) begin
            exp_e = 1'b0;
            exp_f = 1'b0;
            if (i > 0) begin
                if (i % fs_e == 0) begin exp_a = exp_a + fi_x; exp_f = 1'b1; end
                else if (i % es_e == 0) begin exp_a = exp_a + ei_x; exp_e = 1'b1; end
                else exp_a = exp_a + 32'd1;
            end
            if (i == 0)      check(addr_o == exp_a, "R2", "start address", addr_o, exp_a);
            else if (exp_f)  check(addr_o == exp_a, "R5", "frame jump address", addr_o, exp_a);
            else if (exp_e)  check(addr_o == exp_a, "R4", "element jump address", addr_o, exp_a);
            else             check(addr_o == exp_a, "R3", "byte step address", addr_o, exp_a);
            check(elem_bnd_o == exp_e, "R4", "element flag", 32'(elem_bnd_o), 32'(exp_e));
            check(frame_bnd_o == exp_f, "R5", "frame flag", 32'(frame_bnd_o), 32'(exp_f));
            check(done_o == (i == bs_e - 1), "R6", "done flag", 32'(done_o), 32'(i == bs_e - 1));
            if (i == hold_at) begin
                repeat (3) @(negedge clk);
                check(addr_o == exp_a && valid_o, "R7", "hold without next", addr_o, exp_a);
            end
            if (i == restart_at) begin
                cfg_start_addr_i = sa ^ 32'h5555_0000;
                start_i = 1'b1;
                @(negedge clk);
                start_i = 1'b0;
                @(negedge clk);
                check(addr_o == exp_a && valid_o, "R8", "start while active ignored", addr_o, exp_a);
            end
            next_i = 1'b1;
            @(negedge clk);
            next_i = 1'b0;
        end
        check(valid_o == 1'b0, "R6", "valid drops after last", 32'(valid_o), 32'd0);
    endtask

    task automatic test_reset();
        check(valid_o == 1'b0, "R1", "valid at reset", 32'(valid_o), 32'd0);
        check(done_o == 1'b0, "R1", "done at reset", 32'(done_o), 32'd0);
        check(elem_bnd_o == 1'b0 && frame_bnd_o == 1'b0, "R1", "flags at reset",
              32'({elem_bnd_o, frame_bnd_o}), 32'd0);
    endtask

    task automatic test_basic();
        run_xfer(32'h0000_1000, 24, 2, 3, 16'd5, 16'hFFEC, 7, -1);
    endtask

    task automatic test_negative_partial();
        run_xfer(32'h0002_0000, 20, 4, 2, 16'hFFF0, 16'd300, -1, 5);
    endtask

    task automatic test_zero_sizes();
        // R9: all sizes zero act as a single byte
        run_xfer(32'h0000_0040, 0, 0, 0, 16'd9, 16'd9, -1, -1);
        // R9: element size zero acts as 1, frame of two single-byte elements
        run_xfer(32'h0000_0080, 5, 0, 2, 16'd10, 16'd3, -1, -1);
    endtask

    task automatic test_wrap();
        // R10: addresses cross the top of the space
        run_xfer(32'hFFFF_FFFE, 6, 4, 1, 16'd2, 16'd7, 1, -1);
        run_xfer(32'h0000_0002, 4, 1, 2, 16'hFFFC, 16'h8000, -1, -1);
    endtask

    initial begin
        repeat (2) @(negedge clk);
        test_reset();
        rst_n = 1'b1;
        @(negedge clk);
        test_reset();
        test_basic();
        test_negative_partial();
        test_zero_sizes();
        test_wrap();
        repeat (2) @(negedge clk);
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule